// File: doc/BRIEF.md
# Protection register controller for a serial memory

This block owns the protection state that sits at the topmost byte address of a serial nonvolatile memory. It holds two volatile enable latches and three protection bits that survive between sessions: a hardware-lock enable and a two-bit protected-range code. The bus slave shows it each data byte it is about to write. In the same cycle the block says whether an array write may go ahead, or whether the acknowledge must be withheld. Data bytes sent to the top address are decoded as commands that step through a fixed three-step sequence.

The block also gives the read path the register value. It flags when a read must return that value instead of the array byte. The protection bits are plain flops with a parameterized reset default, and storage timing is left to the surrounding logic. Each request is answered combinationally, and the state changes on the next clock edge.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the write-enable and register-enable latches are 0 and the protection bits take the `NV_INIT` default, which is 0. With no request pending, `wr_ok` and `wr_nack` are both 0.
- R2: `reg_q` is {lock-enable, 0, 0, range[1], range[0], register-enable, write-enable, 0}, with bit 7 first. `rd_sel_reg` is 1 exactly when `rd_first` is 1 and `rd_addr` is the top address.
- R3: Two register writes control the write-enable latch. Data with bits 7:1 = 0000001 sets it. Data with bits 7:1 = 0000000 clears it and also clears the register-enable latch. Bit 0 of the data is ignored in every command.
- R4: While the write-enable latch is 0, every array write request gives `wr_ok` = 0 and `wr_nack` = 1.
- R5: Data of the form w00yz11x sets the register-enable latch if the write-enable latch is 1. If the write-enable latch is 0, the same data is refused.
- R6: With the register-enable latch set, data w00yz01x loads lock-enable = w, range = {y,z} and clears the register-enable latch.
- R7: Data w00yz11x never changes the three protection bits.
- R8: The range code protects part of the array: 00 protects nothing, 01 protects addresses 1800h and above, 10 protects 1000h and above, and 11 protects the whole array. A write into a protected address gives `wr_nack` = 1 and `wr_ok` = 0. Any other write with the write-enable latch set gives `wr_ok` = 1.
- R9: When `wp_i` is 1 and lock-enable is 1, a load command (R6) is refused and the protection bits are unchanged.
- R10: Only a first data byte at the top address (`wr_first` = 1) reaches the register. A later byte of a page burst that arrives at the top address is treated as an array write.
- R11: A refused register write asserts `wr_nack` and changes no state. Bits 6:5 not 00, or bits 2:1 = 10, are always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wp_i | input | 1 | Hardware protect pin |
| wr_req | input | 1 | A data byte write is being decided this cycle |
| wr_first | input | 1 | The byte is the first data byte of a random write |
| wr_addr | input | AW | Target byte address |
| wr_data | input | 8 | Data byte |
| wr_ok | output | 1 | The array byte may be written |
| wr_nack | output | 1 | Withhold the acknowledge |
| rd_first | input | 1 | The read is the first byte of a random read |
| rd_addr | input | AW | Read address |
| rd_sel_reg | output | 1 | Return `reg_q` instead of the array byte |
| reg_q | output | 8 | Register value |

## Verification
The bench targets these corner cases:

- **Overlapping pattern 00000010.** It means set-write-enable when the register-enable latch is clear and load-zeros when it is set. A design that mixes the two would enable writes without loading, or would load without the enable step.
- **Hardware lock.** The bench uses a load attempt while locked. A design that ignores the lock would let the register overwrite itself.
- **Command bit 0 set.** The bench sends command values with bit 0 set. A design that decodes bit 0 would refuse them.
- **Burst byte at the top address.** The bench sends a page-burst byte that lands on the top address. A design that routes it to the register would corrupt the protection state.
- **Range boundaries.** The bench writes either side of both range boundaries, 17FFh/1800h and 0FFFh/1000h. An off-by-one decode of the address's top bits would grant or refuse the wrong neighbour.

// File: rtl/wprot_ctrl.sv
module wprot_ctrl #(
  parameter int AW = 13,
  parameter logic [2:0] NV_INIT = 3'b000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_i,
  input  logic          wr_req,
  input  logic          wr_first,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          wr_ok,
  output logic          wr_nack,
  input  logic          rd_first,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_sel_reg,
  output logic [7:0]    reg_q
);
  localparam logic [AW-1:0] TOP = '1;

  logic       wel, rwel, wpen;
  logic [1:0] bp;

  wire       hw_lock = wp_i & wpen;
  wire       to_reg  = wr_first && (wr_addr == TOP);
  wire [2:0] fld     = {wr_data[7], wr_data[4], wr_data[3]};
  wire [1:0] code    = wr_data[2:1];
  wire       pad_ok  = (wr_data[6:5] == 2'b00);

  wire in_block = (bp == 2'b11)
               || (bp == 2'b10 && wr_addr[AW-1])
               || (bp == 2'b01 && (&wr_addr[AW-1:AW-2]));

  wire do_clear   = pad_ok && code == 2'b00 && fld == 3'b000;
  wire do_setwel  = pad_ok && code == 2'b01 && !rwel && fld == 3'b000;
  wire do_load    = pad_ok && code == 2'b01 && rwel && !hw_lock;
  wire do_setrwel = pad_ok && code == 2'b11 && wel;
  wire reg_accept = do_clear | do_setwel | do_load | do_setrwel;
  wire arr_allow  = wel && !in_block;

  assign wr_ok      = wr_req && !to_reg && arr_allow;
  assign wr_nack    = wr_req && (to_reg ? !reg_accept : !arr_allow);
  assign rd_sel_reg = rd_first && (rd_addr == TOP);
  assign reg_q      = {wpen, 2'b00, bp, rwel, wel, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
      {wpen, bp} <= NV_INIT;
    end else if (wr_req && to_reg) begin
      if (do_clear) begin
        wel  <= 1'b0;
        rwel <= 1'b0;
      end
      if (do_setwel)  wel  <= 1'b1;
      if (do_setrwel) rwel <= 1'b1;
      if (do_load) begin
        {wpen, bp} <= fld;
        rwel <= 1'b0;
      end
    end
  end

  a_r5_rwel_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);
  a_r5_rwel_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel) |-> $past(wel));
  a_r4_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (wel && !wr_nack));
  a_r6_load_clears_rwel: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({wpen, bp}) |-> !rwel);
  a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wp_i && wpen) |=> $stable({wpen, bp}));
  a_r11_refused_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && to_reg && wr_nack) |=> $stable(reg_q));
  a_r10_burst_not_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_first) |=> $stable(reg_q));
endmodule

// File: tb/wprot_ctrl_tb.sv
module wprot_ctrl_tb_top;
  localparam int AW = 13;
  localparam logic [AW-1:0] TOP = '1;

  logic clk = 0, rst_n = 0, wp_i = 0;
  logic wr_req = 0, wr_first = 0, rd_first = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ok, wr_nack, rd_sel_reg;
  logic [7:0] reg_q;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  wprot_ctrl #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .wr_req(wr_req), .wr_first(wr_first),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ok(wr_ok), .wr_nack(wr_nack),
    .rd_first(rd_first), .rd_addr(rd_addr), .rd_sel_reg(rd_sel_reg), .reg_q(reg_q));

  always @(negedge clk) begin
    if (wr_req && exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({wr_ok, wr_nack} !== e) begin
        errors++;
        $display("FAIL %s: {ok,nack} actual %b expected %b", t, {wr_ok, wr_nack}, e);
      end
    end
  end

  task automatic wr(input logic first, input logic [AW-1:0] a, input logic [7:0] d,
                    input logic eok, input logic enack, input string t);
    @(posedge clk); #1;
    wr_req = 1; wr_first = first; wr_addr = a; wr_data = d;
    exp_q.push_back({eok, enack});
    tag_q.push_back(t);
    @(posedge clk); #1;
    wr_req = 0; wr_first = 0;
  endtask

  task automatic chk_reg(input logic [7:0] e, input string t);
    @(negedge clk);
    checks++;
    if (reg_q !== e) begin
      errors++;
      $display("FAIL %s: reg_q actual %h expected %h", t, reg_q, e);
    end
  endtask

  task automatic chk_rd(input logic f, input logic [AW-1:0] a, input logic e, input string t);
    @(posedge clk); #1;
    rd_first = f; rd_addr = a;
    @(negedge clk);
    checks++;
    if (rd_sel_reg !== e) begin
      errors++;
      $display("FAIL %s: rd_sel_reg actual %b expected %b", t, rd_sel_reg, e);
    end
    rd_first = 0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_reg(8'h00, "R1 reset value");
    checks++;
    if ({wr_ok, wr_nack} !== 2'b00) begin
      errors++;
      $display("FAIL R1 idle outputs: actual %b expected 00", {wr_ok, wr_nack});
    end
    wr(0, 13'h0123, 8'h55, 0, 1, "R4 write with latch low");
    wr(1, TOP, 8'h03, 0, 0, "R3 set write enable (bit0 set)");
    chk_reg(8'h02, "R3 latch set");
    wr(0, 13'h0123, 8'h55, 1, 0, "R8 range none write ok");
    wr(1, TOP, 8'h07, 0, 0, "R5 set register enable");
    chk_reg(8'h06, "R5 register enable");
    wr(1, TOP, 8'h92, 0, 0, "R6 load lock=1 range=10");
    chk_reg(8'h92, "R6 loaded, rwel cleared");
    wp_i = 1;
    wr(0, 13'h1000, 8'h11, 0, 1, "R8 half boundary protected");
    wr(0, 13'h0FFF, 8'h11, 1, 0, "R8 below half boundary ok");
    wr(1, TOP, 8'h06, 0, 0, "R5 rwel while locked");
    chk_reg(8'h96, "R5 rwel set");
    wr(1, TOP, 8'h0A, 0, 1, "R9 load refused under lock");
    chk_reg(8'h96, "R9 bits unchanged");
    wp_i = 0;
    wr(1, TOP, 8'h0A, 0, 0, "R9 load after pin low");
    chk_reg(8'h0A, "R6 lock=0 range=01");
    wr(0, 13'h1800, 8'h22, 0, 1, "R8 quarter boundary protected");
    wr(0, 13'h17FF, 8'h22, 1, 0, "R8 below quarter ok");
    wr(1, TOP, 8'h06, 0, 0, "R5 rwel again");
    wr(1, TOP, 8'h9E, 0, 0, "R7 w00yz110 accepted");
    chk_reg(8'h0E, "R7 protection bits kept");
    wr(1, TOP, 8'h42, 0, 1, "R11 bad pad bits");
    wr(1, TOP, 8'h04, 0, 1, "R11 code 10 refused");
    chk_reg(8'h0E, "R11 no change");
    wr(0, TOP, 8'h00, 0, 1, "R10 burst byte at top goes to array");
    chk_reg(8'h0E, "R10 register untouched");
    chk_rd(1, TOP, 1, "R2 random read of top");
    chk_rd(0, TOP, 0, "R2 sequential read at top");
    chk_rd(1, TOP - 1, 0, "R2 read below top");
    wr(1, TOP, 8'h1A, 0, 0, "R6 load range=11");
    chk_reg(8'h1A, "R6 full range");
    wr(0, 13'h0000, 8'h33, 0, 1, "R8 full range protects bottom");
    wr(1, TOP, 8'h01, 0, 0, "R3 clear latches");
    chk_reg(8'h18, "R3 cleared");
    wr(0, 13'h0400, 8'h44, 0, 1, "R4 latch low again");
    wr(1, TOP, 8'h06, 0, 1, "R5 rwel refused without wel");
    chk_reg(8'h18, "R5 still clear");
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule